// File: doc/BRIEF.md
# Masked Serial Bit-Stream Correlator

This block compares a window of the last 64 bits of a serial data stream against a stored 64-bit reference word. It counts the positions where the two agree and reports the count as an unsigned 7-bit value. A serially loaded mask register sets which positions take part, so words shorter than 64 bits can be matched. The reference is double-buffered: a new word shifts into a staging register while correlation goes on, and a single load pulse then copies it into the working latch. A loadable threshold sets a flag on every result whose count reaches it. An invert control makes the block count disagreements instead of agreements.

Each accepted data bit starts one correlation. The data input is a valid/ready stream with one bit per transfer. A bit is accepted on a rising clock edge where both `din_valid` and `din_ready` are high. The result output is also a valid/ready stream. A result stays on `res_count`/`res_flag`, unchanged, until it is taken on an edge with `res_ready` high. While a result waits, `din_ready` is low and the whole summing pipeline holds. A source may hold `din_valid` high for any length of time. The staging, mask and threshold registers use plain enables and are never back-pressured. Each of the three shift registers drives a serial output from its last stage, so several blocks can be cascaded.

Top module: `mask_bit_correlator`

## Requirements
- R1: An accepted data bit enters data position 0 and every older bit moves up one position. `data_sout` shows position 63, which is the bit accepted 64 transfers earlier.
- R2: `ref_load` high on an edge copies the staging register (before any shift on that same edge) into the reference latch in that one cycle. Shifting the staging register never changes the latch. A sample accepted on the load edge still uses the old reference.
- R3: A mask bit of 1 makes its position count and a mask bit of 0 makes it add nothing. Mask bits shift in at position 0 under `mask_shift`. A sample accepted on the same edge uses the mask from before that edge.
- R4: With `invert` low, the result is the number of unmasked positions i where window[i] equals reference[i]. The window is the data register including the newly accepted bit. The result covers the full range 0 to 64.
- R5: With `invert` high during the accepting edge, the result counts unmasked positions where window and reference differ.
- R6: A result becomes valid after the third rising edge, counting the accepting edge as the first. With `res_ready` held high, one result can be produced every cycle.
- R7: `res_flag` is 1 exactly when the count it accompanies is greater than or equal to the threshold register. The threshold register is loaded from `thr_value` on an edge with `thr_load` high.
- R8: While `res_valid` is high and `res_ready` is low, `din_ready` is low, and `res_count` and `res_flag` do not change until the result is taken.
- R9: After reset, `res_valid` is 0, the data, staging and reference registers are all zeros, the mask is all ones (so `mask_sout` reads 1) and the threshold is 0.
- R10: `ref_sout` and `mask_sout` show position 63 of the staging and mask registers. That is the bit shifted in 64 shifts earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| din_valid | input | 1 | Data bit offered |
| din_ready | output | 1 | Data bit can be accepted |
| din | input | 1 | Serial data bit |
| data_sout | output | 1 | Last stage of the data register |
| ref_shift | input | 1 | Shift enable of the staging register |
| ref_sin | input | 1 | Serial input of the staging register |
| ref_sout | output | 1 | Last stage of the staging register |
| ref_load | input | 1 | Copy the staging register into the reference latch |
| mask_shift | input | 1 | Shift enable of the mask register |
| mask_sin | input | 1 | Serial input of the mask register (1 = compare) |
| mask_sout | output | 1 | Last stage of the mask register |
| invert | input | 1 | Count disagreements for the sample accepted now |
| thr_load | input | 1 | Load the threshold register |
| thr_value | input | 7 | New threshold value, 0 to 64 |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_count | output | 7 | Correlation count |
| res_flag | output | 1 | Count is at or above the threshold |

## Verification
The hardest situation to create from the ports is a result whose flag sits exactly at the threshold, in both directions, with the count pinned to a chosen value. The stimulus gets there by loading an all-ones reference and full mask and filling the window with zeros. It then shifts in ones one by one, so the count rises through every value from 0 to 64 once, and it repeats this for every threshold from 0 to 64. A second hard case is a reference reload in the middle of a stream while the staging register is still shifting. It is covered by driving data, staging shifts and a load pulse on the same edges, checked against a bench model that updates on each edge. Random stalls on `res_ready` exercise the held-result rule.

// File: rtl/corr_pkg.sv
package corr_pkg;
  localparam int unsigned CORR_BITS_DEF  = 64;
  localparam int unsigned CORR_GROUP_DEF = 8;
  localparam int unsigned CORR_SUPER_DEF = 4;

  typedef enum logic {
    MATCH_AGREE    = 1'b0,
    MATCH_DISAGREE = 1'b1
  } match_mode_e;
endpackage

// File: rtl/corr_sreg.sv
module corr_sreg #(
  parameter int unsigned W = 64,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         sin,
  output logic [W-1:0] q,
  output logic         sout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= INIT;
    else if (shift_en) q <= {q[W-2:0], sin};
  end

  assign sout = q[W-1];

  // R1 / R10: new bit lands at position 0
  a_r1_shift_entry: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> q[0] == $past(sin));
  // R2: contents hold without an enable
  a_r2_shift_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(q));
endmodule

// File: rtl/corr_popcnt_pipe.sv
module corr_popcnt_pipe #(
  parameter int unsigned W     = 64,
  parameter int unsigned GROUP = 8,
  parameter int unsigned SUPER = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic                     in_valid,
  input  logic [W-1:0]             in_bits,
  input  logic [$clog2(W+1)-1:0]   thr,
  output logic                     out_valid,
  output logic [$clog2(W+1)-1:0]   out_count,
  output logic                     out_flag
);
  localparam int unsigned NG  = W / GROUP;
  localparam int unsigned NS  = NG / SUPER;
  localparam int unsigned GCW = $clog2(GROUP + 1);
  localparam int unsigned SCW = $clog2(GROUP * SUPER + 1);
  localparam int unsigned CW  = $clog2(W + 1);

  logic [NG-1:0][GCW-1:0] g_cnt, g_q;
  logic [NS-1:0][SCW-1:0] s_cnt, s_q;
  logic [CW-1:0]          total;
  logic                   v1, v2;

  // stage 1 input: per-group population counts
  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic [GCW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int b = 0; b < GROUP; b++) acc = acc + GCW'(in_bits[g*GROUP+b]);
    end
    assign g_cnt[g] = acc;
  end

  // stage 2 input: sums of SUPER groups
  for (genvar s = 0; s < NS; s++) begin : g_sup
    logic [SCW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int k = 0; k < SUPER; k++) acc = acc + SCW'(g_q[s*SUPER+k]);
    end
    assign s_cnt[s] = acc;
  end

  // stage 3 input: final sum
  always_comb begin
    total = '0;
    for (int s = 0; s < NS; s++) total = total + CW'(s_q[s]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1        <= 1'b0;
      v2        <= 1'b0;
      out_valid <= 1'b0;
      g_q       <= '0;
      s_q       <= '0;
      out_count <= '0;
      out_flag  <= 1'b0;
    end else if (adv) begin
      v1        <= in_valid;
      g_q       <= g_cnt;
      v2        <= v1;
      s_q       <= s_cnt;
      out_valid <= v2;
      out_count <= total;
      out_flag  <= (total >= thr);
    end
  end

  // R6: valid tokens move one stage per advancing cycle
  a_r6_stage_advance: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (v2 == $past(v1)) && (out_valid == $past(v2)));
  // R8: a frozen pipeline keeps its output
  a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(out_count) && $stable(out_flag) && $stable(out_valid));
  // R4: count never exceeds the width
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_count <= CW'(W));
endmodule

// File: rtl/mask_bit_correlator.sv
module mask_bit_correlator
  import corr_pkg::*;
#(
  parameter int unsigned W     = CORR_BITS_DEF,
  parameter int unsigned GROUP = CORR_GROUP_DEF,
  parameter int unsigned SUPER = CORR_SUPER_DEF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   din_valid,
  output logic                   din_ready,
  input  logic                   din,
  output logic                   data_sout,
  input  logic                   ref_shift,
  input  logic                   ref_sin,
  output logic                   ref_sout,
  input  logic                   ref_load,
  input  logic                   mask_shift,
  input  logic                   mask_sin,
  output logic                   mask_sout,
  input  logic                   invert,
  input  logic                   thr_load,
  input  logic [$clog2(W+1)-1:0] thr_value,
  output logic                   res_valid,
  input  logic                   res_ready,
  output logic [$clog2(W+1)-1:0] res_count,
  output logic                   res_flag
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  data_q, stage_q, mask_q, ref_q, win_next, hit_bits;
  logic [CW-1:0] thr_q;
  logic          accept, adv;
  match_mode_e   mode;

  assign adv       = !res_valid || res_ready;
  assign din_ready = adv;
  assign accept    = din_valid && adv;

  corr_sreg #(.W(W), .INIT('0)) u_data (
    .clk(clk), .rst_n(rst_n), .shift_en(accept), .sin(din),
    .q(data_q), .sout(data_sout));

  corr_sreg #(.W(W), .INIT('0)) u_stage (
    .clk(clk), .rst_n(rst_n), .shift_en(ref_shift), .sin(ref_sin),
    .q(stage_q), .sout(ref_sout));

  corr_sreg #(.W(W), .INIT('1)) u_mask (
    .clk(clk), .rst_n(rst_n), .shift_en(mask_shift), .sin(mask_sin),
    .q(mask_q), .sout(mask_sout));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      thr_q <= '0;
    end else begin
      if (ref_load) ref_q <= stage_q;
      if (thr_load) thr_q <= thr_value;
    end
  end

  // window as it stands once the offered bit is in
  assign win_next = {data_q[W-2:0], din};
  assign mode     = invert ? MATCH_DISAGREE : MATCH_AGREE;

  always_comb begin
    if (mode == MATCH_DISAGREE) hit_bits = (win_next ^ ref_q) & mask_q;
    else                        hit_bits = ~(win_next ^ ref_q) & mask_q;
  end

  corr_popcnt_pipe #(.W(W), .GROUP(GROUP), .SUPER(SUPER)) u_sum (
    .clk(clk), .rst_n(rst_n), .adv(adv), .in_valid(accept),
    .in_bits(hit_bits), .thr(thr_q),
    .out_valid(res_valid), .out_count(res_count), .out_flag(res_flag));

  // R2: the latch changes only on a load pulse
  a_r2_ref_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_load |=> $stable(ref_q));
  // R8: a waiting result stays put
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid && $stable(res_count) && $stable(res_flag));
  // R8: no data bit enters while a result waits
  a_r8_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready && !mask_shift) |=> $stable(data_q));
endmodule

// File: tb/mask_bit_correlator_tb_top.sv
module mask_bit_correlator_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din_valid = 0, din = 0, ref_shift = 0, ref_sin = 0, ref_load = 0;
  logic mask_shift = 0, mask_sin = 0, invert = 0, thr_load = 0, res_ready = 1;
  logic [6:0] thr_value = '0;
  logic din_ready, data_sout, ref_sout, mask_sout, res_valid, res_flag;
  logic [6:0] res_count;

  always #10 clk = ~clk;

  mask_bit_correlator dut_i (
    .clk(clk), .rst_n(rst_n), .din_valid(din_valid), .din_ready(din_ready),
    .din(din), .data_sout(data_sout), .ref_shift(ref_shift), .ref_sin(ref_sin),
    .ref_sout(ref_sout), .ref_load(ref_load), .mask_shift(mask_shift),
    .mask_sin(mask_sin), .mask_sout(mask_sout), .invert(invert),
    .thr_load(thr_load), .thr_value(thr_value), .res_valid(res_valid),
    .res_ready(res_ready), .res_count(res_count), .res_flag(res_flag));

  int checks = 0, fails = 0;
  bit started = 0, saw0 = 0, saw64 = 0;
  string ph = "R4";
  logic [63:0] md, ms, mr, mm;
  logic [6:0]  mthr;
  logic [7:0]  expq[$];
  logic [15:0] lf = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model, updated on the same edges as the design
  always @(posedge clk) begin
    if (!rst_n) begin
      md = '0; ms = '0; mr = '0; mm = '1; mthr = '0; expq.delete();
    end else begin
      if (res_valid && res_ready && expq.size() > 0) void'(expq.pop_front());
      if (din_valid && din_ready) begin
        logic [63:0] nd;
        int c;
        nd = {md[62:0], din};
        c = 0;
        for (int i = 0; i < 64; i++)
          if (mm[i] && ((nd[i] == mr[i]) != invert)) c++;
        expq.push_back({(c >= int'(mthr)), 7'(c)});
        md = nd;
      end
      if (ref_load) mr = ms;
      if (ref_shift) ms = {ms[62:0], ref_sin};
      if (mask_shift) mm = {mm[62:0], mask_sin};
      if (thr_load) mthr = thr_value;
    end
  end

  // scoreboard and serial-output checks away from the active edge
  always @(negedge clk) begin
    if (started && rst_n) begin
      chk(data_sout == md[63], "R1 data_sout", data_sout, md[63]);
      chk(ref_sout == ms[63], "R10 ref_sout", ref_sout, ms[63]);
      chk(mask_sout == mm[63], "R10 mask_sout", mask_sout, mm[63]);
      if (res_valid) begin
        if (expq.size() == 0) chk(0, {ph, " unexpected result R6"}, 1, 0);
        else begin
          chk(res_count == expq[0][6:0], {ph, " count"}, res_count, expq[0][6:0]);
          chk(res_flag == expq[0][7], {ph, " R7 flag"}, res_flag, expq[0][7]);
          if (res_count == 7'd64) saw64 = 1;
          if (res_count == 7'd0) saw0 = 1;
        end
      end
    end
  end

  task automatic nb(output logic b);
    b = lf[0];
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  task automatic drain();
    @(negedge clk);
    din_valid = 0; res_ready = 1; ref_shift = 0; mask_shift = 0; ref_load = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic shift_ref(input logic [63:0] w);
    for (int i = 63; i >= 0; i--) begin
      @(negedge clk); ref_shift = 1; ref_sin = w[i];
    end
    @(negedge clk); ref_shift = 0;
  endtask

  task automatic shift_mask(input logic [63:0] w);
    for (int i = 63; i >= 0; i--) begin
      @(negedge clk); mask_shift = 1; mask_sin = w[i];
    end
    @(negedge clk); mask_shift = 0;
  endtask

  task automatic pulse_load();
    @(negedge clk); ref_load = 1;
    @(negedge clk); ref_load = 0;
  endtask

  task automatic load_thr(input int t);
    drain();
    thr_load = 1; thr_value = 7'(t);
    @(negedge clk); thr_load = 0;
  endtask

  // mode: 0 fixed bit, 1 random bits
  task automatic stream(input int n, input bit rnd, input logic fixed);
    logic b;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      nb(b);
      din_valid = 1; din = rnd ? b : fixed;
    end
    @(negedge clk); din_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(res_valid == 0, "R9 res_valid in reset", res_valid, 0);
    chk(mask_sout == 1, "R9 mask all ones", mask_sout, 1);
    chk(data_sout == 0 && ref_sout == 0, "R9 registers clear", data_sout | ref_sout, 0);
    rst_n = 1;
    started = 1;
    @(negedge clk);
    chk(din_ready == 1, "R9 ready after reset", din_ready, 1);

    // R4: all agree then all disagree
    ph = "R4 extremes";
    shift_ref(64'hF0F0_1234_ABCD_0F0F);
    pulse_load();
    for (int i = 63; i >= 0; i--) begin
      @(negedge clk); din_valid = 1; din = mr[i];
    end
    for (int i = 63; i >= 0; i--) begin
      @(negedge clk); din_valid = 1; din = ~mr[i];
    end
    drain();

    // R6: latency of a single sample
    @(negedge clk); din_valid = 1; din = 1;
    @(negedge clk); din_valid = 0;
    chk(res_valid == 0, "R6 not valid after edge 1", res_valid, 0);
    @(negedge clk);
    chk(res_valid == 0, "R6 not valid after edge 2", res_valid, 0);
    @(negedge clk);
    chk(res_valid == 1, "R6 valid after edge 3", res_valid, 1);
    @(negedge clk);
    chk(res_valid == 0, "R6 taken after one cycle", res_valid, 0);

    // R7: every threshold against a rising count 0..64
    ph = "R7 threshold";
    shift_ref('1);
    pulse_load();
    for (int t = 0; t <= 64; t++) begin
      load_thr(t);
      stream(64, 0, 1'b0);
      stream(64, 0, 1'b1);
    end
    load_thr(20);

    // R5: disagreement counting
    ph = "R5 invert";
    shift_ref(64'h0123_4567_89AB_CDEF);
    pulse_load();
    @(negedge clk); invert = 1;
    stream(200, 1, 1'b0);
    drain();
    invert = 0;

    // R3: short word and sparse masks
    ph = "R3 mask";
    shift_mask(64'h0000_0000_0000_FFFF);
    stream(150, 1, 1'b0);
    shift_mask(64'h8421_F00F_0A50_1248);
    stream(150, 1, 1'b0);
    @(negedge clk); invert = 1;
    stream(100, 1, 1'b0);
    drain();
    invert = 0;
    shift_mask('0);
    stream(70, 1, 1'b0);
    drain();

    // R2: reload while data streams and staging shifts
    ph = "R2 reload";
    shift_mask('1);
    for (int i = 0; i < 160; i++) begin
      logic b1, b2;
      @(negedge clk);
      nb(b1); nb(b2);
      din_valid = 1; din = b1;
      ref_shift = 1; ref_sin = b2;
      ref_load = (i == 40 || i == 100 || i == 101);
    end
    @(negedge clk); din_valid = 0; ref_shift = 0; ref_load = 0;
    drain();

    // R8: held result under back-pressure
    ph = "R8 backpressure";
    @(negedge clk); res_ready = 0; din_valid = 1; din = 1;
    repeat (5) @(negedge clk);
    begin
      logic [6:0] hc;
      logic hf;
      chk(res_valid == 1, "R8 result waiting", res_valid, 1);
      chk(din_ready == 0, "R8 din_ready low", din_ready, 0);
      hc = res_count; hf = res_flag;
      repeat (3) begin
        @(negedge clk);
        chk(res_count == hc && res_flag == hf, "R8 result held", res_count, hc);
      end
    end
    for (int i = 0; i < 400; i++) begin
      logic a, b, c;
      @(negedge clk);
      nb(a); nb(b); nb(c);
      res_ready = a | b; din_valid = b | c; din = c;
    end
    drain();
    chk(expq.size() == 0, "R6 all results delivered", expq.size(), 0);
    chk(saw64, "R4 count 64 seen", saw64, 1);
    chk(saw0, "R4 count 0 seen", saw0, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule